// File: doc/BRIEF.md
# Table Base Register Negotiator

The negotiator programs a bank of up to eight 64-bit table base registers through a simple request/acknowledge register port. After a start pulse it visits the registers in ascending index order. For each one it reads the current contents to learn the table type and the entry-size field. If the type is zero, the register is left alone. Otherwise it writes a configuration word. That word combines a page-aligned physical base supplied per register with the read type and entry size, a fixed write-allocate/write-back cache code, the current shareability, a valid flag, a page-size code and a size field.

Every write is followed by a readback. If the device reports a different shareability, the negotiator adopts the reported value and writes again. If only the page size failed to stick, it tries the next smaller page size (64K, then 16K, then 4K) and writes again. Any other difference ends the whole run with an error that names the failing register. The shareability and page size that were agreed carry over to the following registers. A per-register success mask and a failure flag are held until the next start.

Top module: `tbr_negotiator`

## Requirements
- R1: While reset is asserted and after its release, req_o, done_o, busy_o and fail_o are 0 and ok_mask_o is all zero.
- R2: Register k is accessed at byte offset 8*k (addr_o = {k, 3'b000}). The first access to each register is a read (we_o = 0). A request holds its address, direction and data stable until ack_i.
- R3: A register whose read-back type field, bits [58:56], is 0 receives no write and keeps its ok bit at 0. Negotiation then continues with the next register.
- R4: The written word is laid out as follows. Bit 63 is 1. Bits [61:59] are 3'b101 (write-allocate, write-back). Bits [58:56] hold the type as read and bits [52:48] hold the entry-size field as read. Bits [47:12] hold the register's base_i slice, bits [11:10] the shareability and bits [9:8] the page code (0 = 4K, 1 = 16K, 2 = 64K). Bits [7:0] hold (host page / table page) - 1. All other bits are 0.
- R5: When the readback's bits [11:10] differ from the written ones, the readback's shareability is adopted and the register is written again with the page size unchanged.
- R6: When shareability matches but bits [9:8] differ, the page code steps 2 to 1 or 1 to 0 and the register is written again. With a 4K page, no step occurs.
- R7: Any remaining difference between the written word and its readback stops the run: fail_o = 1, fail_idx_o = failing index, and no later register is accessed.
- R8: The shareability and page code agreed for one register are the starting values for the next register in the same run.
- R9: A readback equal to the written word sets that register's ok_mask_o bit. ok_mask_o does not change while the block is idle.
- R10: No register is written more than MAX_TRIES times in one run. A mismatch that would need a further write is reported as a failure of that register.
- R11: done_o is a one-cycle pulse at the end of a run, followed by idle. A start_i pulse during a run is ignored.
- R12: Each run starts with inner-shareable code 2'b01 and page code HOST_PG (default 2, 64K). With this default, the size field is 15 at 4K, 3 at 16K and 0 at 64K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a negotiation run (ignored while busy) |
| base_i | input | NUM_REGS*36 | Per-register page-aligned physical base, bits [47:12], register k at slice k |
| req_o | output | 1 | Register access request |
| we_o | output | 1 | Access is a write |
| addr_o | output | IDX_W+3 | Byte offset of the register |
| wdata_o | output | 64 | Write data |
| ack_i | input | 1 | Access complete; rdata_i valid for reads |
| rdata_i | input | 64 | Read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_mask_o | output | NUM_REGS | Per-register success bits |
| fail_o | output | 1 | Run ended on an unresolved mismatch |
| fail_idx_o | output | IDX_W | Index of the failing register |

## Verification
A cooperative device that accepts every value isolates the plain write path, the field layout and the initial settings. Type-zero registers scattered through the bank show that skipping leaves both the register contents and the mask untouched. Devices that force a shareability, or that cap the page size at 4K, separate the adoption step from the page step-down, and the registers after them show whether the agreed values carry forward. Three further devices each end the run differently: one corrupts an address bit, one corrupts the page field so that stepping runs out, and one flips shareability on every write so that only the attempt limit ends the run.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int WORD_W    = 64;
  localparam int VALID_BIT = 63;
  localparam int CACHE_LO  = 59;
  localparam int TYPE_LO   = 56;
  localparam int ESZ_LO    = 48;
  localparam int BASE_LO   = 12;
  localparam int BASE_W    = 36;
  localparam int SHR_LO    = 10;
  localparam int PG_LO     = 8;
  localparam int SZ_W      = 8;

  localparam logic [2:0] TYPE_NONE  = 3'd0;
  localparam logic [2:0] CACHE_WAWB = 3'b101;
  localparam logic [1:0] SHR_INNER  = 2'b01;
  localparam logic [1:0] PG_4K      = 2'd0;
  localparam logic [1:0] PG_16K     = 2'd1;
  localparam logic [1:0] PG_64K     = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_CFG, ST_WR, ST_RD_BACK, ST_EVAL, ST_DONE
  } tbr_state_e;
endpackage

// File: rtl/tbr_value_build.sv
module tbr_value_build
  import tbr_pkg::*;
#(
  parameter int HOST_PG = 2
) (
  input  logic [BASE_W-1:0] base_i,
  input  logic [2:0]        type_i,
  input  logic [4:0]        esz_i,
  input  logic [1:0]        shr_i,
  input  logic [1:0]        pg_i,
  output logic [WORD_W-1:0] value_o
);
  logic [2:0]      shamt;
  logic [SZ_W-1:0] ratio_m1;

  always_comb begin
    shamt    = (int'(pg_i) < HOST_PG) ? 3'(2 * (HOST_PG - int'(pg_i))) : 3'd0;
    ratio_m1 = SZ_W'((9'd1 << shamt) - 9'd1);
    value_o                   = '0;
    value_o[VALID_BIT]        = 1'b1;
    value_o[CACHE_LO +: 3]    = CACHE_WAWB;
    value_o[TYPE_LO +: 3]     = type_i;
    value_o[ESZ_LO +: 5]      = esz_i;
    value_o[BASE_LO +: BASE_W] = base_i;
    value_o[SHR_LO +: 2]      = shr_i;
    value_o[PG_LO +: 2]       = pg_i;
    value_o[SZ_W-1:0]         = ratio_m1;
  end
endmodule

// File: rtl/tbr_rb_cmp.sv
module tbr_rb_cmp
  import tbr_pkg::*;
(
  input  logic [WORD_W-1:0] wr_i,
  input  logic [WORD_W-1:0] rd_i,
  output logic              shr_diff_o,
  output logic              pg_diff_o,
  output logic              any_diff_o,
  output logic [1:0]        rd_shr_o
);
  assign shr_diff_o = wr_i[SHR_LO +: 2] != rd_i[SHR_LO +: 2];
  assign pg_diff_o  = wr_i[PG_LO +: 2]  != rd_i[PG_LO +: 2];
  assign any_diff_o = wr_i != rd_i;
  assign rd_shr_o   = rd_i[SHR_LO +: 2];
endmodule

// File: rtl/tbr_pg_step.sv
module tbr_pg_step
  import tbr_pkg::*;
(
  input  logic [1:0] pg_i,
  output logic       can_step_o,
  output logic [1:0] pg_dn_o
);
  always_comb begin
    can_step_o = 1'b0;
    pg_dn_o    = pg_i;
    unique case (pg_i)
      PG_64K:  begin can_step_o = 1'b1; pg_dn_o = PG_16K; end
      PG_16K:  begin can_step_o = 1'b1; pg_dn_o = PG_4K;  end
      default: ;
    endcase
  end
endmodule

// File: rtl/tbr_negotiator.sv
module tbr_negotiator
  import tbr_pkg::*;
#(
  parameter int NUM_REGS  = 8,
  parameter int HOST_PG   = 2,
  parameter int MAX_TRIES = 8,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W   = IDX_W + 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [NUM_REGS*BASE_W-1:0] base_i,
  output logic                       req_o,
  output logic                       we_o,
  output logic [ADDR_W-1:0]          addr_o,
  output logic [WORD_W-1:0]          wdata_o,
  input  logic                       ack_i,
  input  logic [WORD_W-1:0]          rdata_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [NUM_REGS-1:0]        ok_mask_o,
  output logic                       fail_o,
  output logic [IDX_W-1:0]           fail_idx_o
);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [1:0] PG_INIT = 2'(HOST_PG);

  tbr_state_e          state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [2:0]          type_q;
  logic [4:0]          esz_q;
  logic [1:0]          shr_q, pg_q;
  logic [WORD_W-1:0]   wr_q, rb_q;
  logic [TRY_W-1:0]    tries_q;
  logic [NUM_REGS-1:0] ok_q;
  logic                fail_q;
  logic [IDX_W-1:0]    fail_idx_q;

  logic [WORD_W-1:0]   built;
  logic [BASE_W-1:0]   base_sel;
  logic                shr_diff, pg_diff, any_diff, can_step;
  logic [1:0]          rd_shr, pg_dn;
  logic                last_reg, tries_out;

  assign base_sel  = base_i[int'(idx_q)*BASE_W +: BASE_W];
  assign last_reg  = idx_q == LAST_IDX;
  assign tries_out = tries_q >= TRY_W'(MAX_TRIES);

  tbr_value_build #(.HOST_PG(HOST_PG)) u_build (
    .base_i (base_sel), .type_i(type_q), .esz_i(esz_q),
    .shr_i  (shr_q),    .pg_i  (pg_q),   .value_o(built)
  );

  tbr_rb_cmp u_cmp (
    .wr_i(wr_q), .rd_i(rb_q), .shr_diff_o(shr_diff), .pg_diff_o(pg_diff),
    .any_diff_o(any_diff), .rd_shr_o(rd_shr)
  );

  tbr_pg_step u_step (.pg_i(pg_q), .can_step_o(can_step), .pg_dn_o(pg_dn));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      type_q     <= '0;
      esz_q      <= '0;
      shr_q      <= SHR_INNER;
      pg_q       <= PG_INIT;
      wr_q       <= '0;
      rb_q       <= '0;
      tries_q    <= '0;
      ok_q       <= '0;
      fail_q     <= 1'b0;
      fail_idx_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q      <= '0;
          ok_q       <= '0;
          fail_q     <= 1'b0;
          fail_idx_q <= '0;
          shr_q      <= SHR_INNER;
          pg_q       <= PG_INIT;
          state_q    <= ST_RD_CFG;
        end
        ST_RD_CFG: if (ack_i) begin
          type_q  <= rdata_i[TYPE_LO +: 3];
          esz_q   <= rdata_i[ESZ_LO +: 5];
          tries_q <= '0;
          if (rdata_i[TYPE_LO +: 3] == TYPE_NONE) begin
            if (last_reg) state_q <= ST_DONE;
            else idx_q <= idx_q + 1'b1;
          end else begin
            state_q <= ST_WR;
          end
        end
        ST_WR: if (ack_i) begin
          wr_q    <= built;
          tries_q <= tries_q + 1'b1;
          state_q <= ST_RD_BACK;
        end
        ST_RD_BACK: if (ack_i) begin
          rb_q    <= rdata_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          if (shr_diff || (pg_diff && can_step)) begin
            if (shr_diff) shr_q <= rd_shr;
            else          pg_q  <= pg_dn;
            if (tries_out) begin
              fail_q     <= 1'b1;
              fail_idx_q <= idx_q;
              state_q    <= ST_DONE;
            end else begin
              state_q <= ST_WR;
            end
          end else if (any_diff) begin
            fail_q     <= 1'b1;
            fail_idx_q <= idx_q;
            state_q    <= ST_DONE;
          end else begin
            ok_q[idx_q] <= 1'b1;
            if (last_reg) state_q <= ST_DONE;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_RD_CFG;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o      = (state_q == ST_RD_CFG) || (state_q == ST_WR) || (state_q == ST_RD_BACK);
  assign we_o       = state_q == ST_WR;
  assign addr_o     = {idx_q, 3'b000};
  assign wdata_o    = we_o ? built : '0;
  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = state_q == ST_DONE;
  assign ok_mask_o  = ok_q;
  assign fail_o     = fail_q;
  assign fail_idx_o = fail_idx_q;

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));

  // R3
  skip_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD_CFG) && ack_i && (rdata_i[TYPE_LO +: 3] == TYPE_NONE) |=> !we_o);

  // R6
  pg_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && (pg_q != $past(pg_q)) |-> pg_q < $past(pg_q));

  // R7
  fail_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> done_o);

  // R9
  mask_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(ok_mask_o));

  // R10
  try_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tries_q <= TRY_W'(MAX_TRIES));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
endmodule

// File: tb/tbr_negotiator_tb.sv
module tbr_negotiator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;
  localparam int HOST = 2;
  localparam int MAXT = 8;
  localparam int BW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NREG*BW-1:0] base;
  logic req, we, ack = 1'b0, busy, done, fail;
  logic [5:0] addr;
  logic [63:0] wdata, rdata = '0;
  logic [NREG-1:0] ok_mask;
  logic [2:0] fail_idx;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbr_negotiator u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .req_o(req), .we_o(we), .addr_o(addr), .wdata_o(wdata),
    .ack_i(ack), .rdata_i(rdata), .busy_o(busy), .done_o(done),
    .ok_mask_o(ok_mask), .fail_o(fail), .fail_idx_o(fail_idx)
  );

  // device model configuration
  logic [2:0]  d_type [NREG];
  logic [4:0]  d_esz  [NREG];
  logic        d_fen  [NREG];
  logic [1:0]  d_fshr [NREG];
  logic        d_flip [NREG];
  logic [1:0]  d_pgmax[NREG];
  logic [63:0] d_corr [NREG];
  logic [63:0] d_store[NREG];
  int          wr_count = 0;
  int          proto_err = 0;
  int          last_idx = -1;
  logic [63:0] first_wr = '0;
  bit          first_seen = 1'b0;

  typedef struct packed {
    logic [NREG-1:0] mask;
    logic            fail;
    logic [2:0]      idx;
    logic [31:0]     writes;
  } exp_t;
  exp_t  expq[$];
  string tagq[$];
  int    done_cnt = 0;
  logic [63:0] exp_store[NREG];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dev_apply(input int i, input logic [63:0] v);
    logic [63:0] r;
    r = v;
    if (d_fen[i]) r[11:10] = d_fshr[i];
    if (d_flip[i]) r[11:10] = v[11:10] ^ 2'b01;
    if (r[9:8] > d_pgmax[i]) r[9:8] = d_pgmax[i];
    return r ^ d_corr[i];
  endfunction

  function automatic logic [63:0] tb_build(input int i, input logic [1:0] shr, input logic [1:0] pg);
    logic [63:0] v;
    v = '0;
    v[63] = 1'b1;
    v[61:59] = 3'b101;
    v[58:56] = d_type[i];
    v[52:48] = d_esz[i];
    v[47:12] = base[i*BW +: BW];
    v[11:10] = shr;
    v[9:8] = pg;
    v[7:0] = 8'((1 << (2*(HOST - int'(pg)))) - 1);
    return v;
  endfunction

  // device: serviced at negedge, ack seen by the design at the next posedge
  initial begin
    forever begin
      @(negedge clk);
      if (ack) ack = 1'b0;
      else if (req) begin
        int k;
        k = int'(addr >> 3);
        if (addr[2:0] != 3'b000 || k >= NREG) proto_err++;
        if (k != last_idx && we) proto_err++;
        last_idx = k;
        if (we) begin
          wr_count++;
          if (!first_seen) begin first_wr = wdata; first_seen = 1'b1; end
          d_store[k] = dev_apply(k, wdata);
        end
        rdata = d_store[k];
        ack = 1'b1;
      end
    end
  end

  // monitor: pops expectations at each done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (expq.size() == 0) chk(1'b0, "R11", 64'd1, 64'd0);
        else begin
          exp_t e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          chk(ok_mask == e.mask, t, 64'(ok_mask), 64'(e.mask));
          chk(fail == e.fail, "R7", 64'(fail), 64'(e.fail));
          if (e.fail) chk(fail_idx == e.idx, "R7", 64'(fail_idx), 64'(e.idx));
          chk(wr_count == int'(e.writes), t, 64'(wr_count), 64'(e.writes));
        end
        done_cnt++;
      end
    end
  end

  task automatic set_default();
    for (int i = 0; i < NREG; i++) begin
      d_type[i] = 3'(1 + i % 4);
      d_esz[i] = 5'(7 + i);
      d_fen[i] = 1'b0;
      d_fshr[i] = 2'b00;
      d_flip[i] = 1'b0;
      d_pgmax[i] = 2'd2;
      d_corr[i] = '0;
    end
  endtask

  task automatic run(input string tag, input bit poke_start);
    exp_t e;
    logic [1:0] shr, pg;
    bit stop;
    int n;
    for (int i = 0; i < NREG; i++) begin
      d_store[i] = '0;
      d_store[i][58:56] = d_type[i];
      d_store[i][52:48] = d_esz[i];
      exp_store[i] = d_store[i];
    end
    shr = 2'b01; pg = 2'(HOST); stop = 1'b0;
    e = '0;
    for (int i = 0; i < NREG; i++) begin
      int tries;
      if (stop || d_type[i] == 3'd0) continue;
      tries = 0;
      forever begin
        logic [63:0] v, r;
        v = tb_build(i, shr, pg);
        tries++;
        e.writes++;
        r = dev_apply(i, v);
        exp_store[i] = r;
        if (r[11:10] != v[11:10] || (r[9:8] != v[9:8] && pg != 2'd0)) begin
          if (r[11:10] != v[11:10]) shr = r[11:10];
          else pg = pg - 2'd1;
          if (tries >= MAXT) begin e.fail = 1'b1; e.idx = 3'(i); stop = 1'b1; break; end
        end else if (r != v) begin
          e.fail = 1'b1; e.idx = 3'(i); stop = 1'b1; break;
        end else begin
          e.mask[i] = 1'b1; break;
        end
      end
    end
    expq.push_back(e);
    tagq.push_back(tag);
    wr_count = 0; proto_err = 0; last_idx = -1; first_seen = 1'b0;
    n = done_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke_start) begin
      repeat (7) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait (done_cnt == n + 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R11", 64'({done, busy}), 64'd0);
    chk(proto_err == 0, "R2", 64'(proto_err), 64'd0);
    for (int i = 0; i < NREG; i++)
      chk(d_store[i] == exp_store[i], (d_type[i] == 3'd0) ? "R3" : "R4", d_store[i], exp_store[i]);
    repeat (3) @(negedge clk);
    chk(ok_mask == e.mask, "R9", 64'(ok_mask), 64'(e.mask));
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) base[i*BW +: BW] = 36'h9_8765_4300 + 36'(i * 'h111);
    set_default();
    repeat (3) @(negedge clk);
    chk(req == 0 && done == 0 && busy == 0 && fail == 0, "R1", 64'({req, done, busy, fail}), 64'd0);
    chk(ok_mask == '0, "R1", 64'(ok_mask), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req == 0 && busy == 0 && ok_mask == '0, "R1", 64'({req, busy, ok_mask}), 64'd0);

    // cooperative device
    run("R9", 1'b0);
    chk(first_wr == tb_build(0, 2'b01, 2'd2), "R12", first_wr, tb_build(0, 2'b01, 2'd2));
    chk(first_wr[7:0] == 8'd0, "R12", 64'(first_wr[7:0]), 64'd0);

    // scattered type-zero registers
    set_default();
    d_type[1] = 3'd0; d_type[4] = 3'd0; d_type[7] = 3'd0;
    run("R3", 1'b0);

    // forced shareability, carried forward
    set_default();
    d_fen[2] = 1'b1; d_fshr[2] = 2'b10;
    run("R5", 1'b0);
    chk(d_store[3][11:10] == 2'b10, "R8", 64'(d_store[3][11:10]), 64'd2);

    // page capped at 4K, carried forward
    set_default();
    d_pgmax[0] = 2'd0;
    run("R6", 1'b0);
    chk(d_store[5][9:8] == 2'd0 && d_store[5][7:0] == 8'd15, "R8", d_store[5][15:0], 64'h000f);

    // address bit corrupted
    set_default();
    d_corr[5] = 64'h1 << 20;
    run("R7", 1'b0);

    // page field corrupted so stepping runs out
    set_default();
    d_corr[3] = 64'h1 << 9;
    run("R6", 1'b0);

    // shareability flips on every write
    set_default();
    d_flip[1] = 1'b1;
    run("R10", 1'b0);

    // start pulse while busy
    set_default();
    run("R11", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule